// File: doc/BRIEF.md
# Teletext Page Store Host Port

This block is the byte-wide processor interface to a teletext character page store. It holds eleven control registers that the host can only write. Behind them sits one data register for reading and writing page bytes, and one status register that can only be read. Control register values are driven out on a flat bus so that neighbouring logic can decode them. The host picks a chapter, a row and a column through three pointer registers. It then moves character bytes through the data register, and the column pointer advances after each access. This lets a whole row, or a whole page, be streamed without reprogramming the address.

After reset the block runs a fill sequencer. The sequencer writes one byte per clock. Every location of the store becomes a space (0x20), except chapter 0, row 0, column 7, which becomes an alpha-white attribute (0x07). While the fill runs the block raises `busy`, and data-register accesses have no effect. The extra broadcast packet is kept at the row-23 address. A select bit in the chapter register marks it, and the host reaches its 40 bytes by pointing the row at 23 and the column at the byte position.

Top module: `ttx_page_port`

## Requirements
- R1: Reads of register addresses 0 to 10 and 12 to 15 return 0x00 on `rdata`. Registers 0 to 10 are written with `wr` at their address, and their contents appear on `ctrl_o` at bits [8k+7:8k] for register k.
- R2: On reset every control register is 0x00, except registers 5 and 6, which are 0x03. `rdata` is 0x00.
- R3: After reset is released, `busy` stays high for exactly CHAPTERS*ROWS*COLS clock cycles, because the fill writes one byte per cycle.
- R4: After the fill, every byte of the store reads 0x20, except chapter 0, row 0, column 7, which reads 0x07.
- R5: The data register (address 11) reaches the byte at chapter = register 8 bits [2:0], row = register 9 bits [4:0], column = register 10 bits [5:0]. A byte written there reads back unchanged. Register 8 bit 3 marks the extra packet and does not change the addressing, so packet bytes sit at row 23, columns 0 to 39.
- R6: When register 1 bit 2 is 1, a read of address 11 returns {field_60hz, 6'b000000, sync_ok} and does not move the pointers.
- R7: Each write of address 11, and each read of address 11 with register 1 bit 2 at 0, increments the column in register 10. When the column is 39 or more it returns to 0 and the row in register 9 increments, and row 24 wraps to row 0.
- R8: While `busy` is high, reads and writes of address 11 change neither the pointers nor `rdata`.
- R9: `rdata` is registered. It changes only in the cycle after a `rd` strobe and holds its value otherwise.
- R10: If the pointers name a location outside the store (chapter at least CHAPTERS), a write is dropped without touching any other byte, a read returns 0x00, and the column still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, starts the fill |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe |
| field_60hz | input | 1 | Status: 60 Hz field timing detected |
| sync_ok | input | 1 | Status: sync signal quality good |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Fill sequencer running |
| ctrl_o | output | 88 | Control registers 0 to 10, register k at bits [8k+7:8k] |

## Verification
The properties assume the host asserts at most one of `wr` and `rd` in a cycle and presents a single address with it. They also assume the status inputs are stable around a status read, and that the host never writes register 10 in the same cycle as an access to address 11. The bench drives every strobe for one cycle on the falling edge, always with one address, and leaves idle cycles between accesses, so all of these hold. It sweeps the whole store at the default two-chapter size. Every expected byte is computed from its chapter, row and column.

// File: rtl/ttx_page_port.sv
module ttx_page_port #(
  parameter int CHAPTERS = 2,
  parameter int ROWS     = 25,
  parameter int COLS     = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr,
  input  logic        rd,
  input  logic        field_60hz,
  input  logic        sync_ok,
  output logic [7:0]  rdata,
  output logic        busy,
  output logic [87:0] ctrl_o
);
  localparam int NREG  = 11;
  localparam int DEPTH = CHAPTERS * ROWS * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [3:0] DATA_ADDR = 4'd11;

  logic [7:0]    regs [NREG];
  logic [7:0]    mem  [DEPTH];
  logic [AW-1:0] fill_idx;
  logic          filling;
  logic [AW-1:0] lin;

  wire       sel_stat = regs[1][2];
  wire [2:0] chap     = regs[8][2:0];
  wire [4:0] row      = regs[9][4:0];
  wire [5:0] col      = regs[10][5:0];

  wire hit      = (addr == DATA_ADDR) && !filling;
  wire data_wr  = wr && hit;
  wire data_rd  = rd && hit && !sel_stat;
  wire step     = data_wr || data_rd;
  wire col_end  = col >= 6'(COLS - 1);
  wire in_range = (int'(chap) < CHAPTERS) && (int'(row) < ROWS) && (int'(col) < COLS);

  wire [5:0] col_nxt = col_end ? 6'd0 : col + 6'd1;
  wire [4:0] row_nxt = (row >= 5'(ROWS - 1)) ? 5'd0 : row + 5'd1;

  always_comb lin = AW'((int'(chap) * ROWS + int'(row)) * COLS + int'(col));

  assign busy = filling;

  for (genvar k = 0; k < NREG; k++) begin : g_out
    assign ctrl_o[8*k +: 8] = regs[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 5 || i == 6) ? 8'h03 : 8'h00;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr && addr == 4'(i)) regs[i] <= wdata;
      if (step) begin
        regs[10] <= {2'b00, col_nxt};
        if (col_end) regs[9] <= {3'b000, row_nxt};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling  <= 1'b1;
      fill_idx <= '0;
    end else if (filling) begin
      if (fill_idx == AW'(DEPTH - 1)) filling <= 1'b0;
      else fill_idx <= fill_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (filling)
      mem[fill_idx] <= (fill_idx == AW'(7)) ? 8'h07 : 8'h20;
    else if (data_wr && in_range)
      mem[lin] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= 8'h00;
    else if (rd) begin
      if (addr != DATA_ADDR)
        rdata <= 8'h00;
      else if (!filling) begin
        if (sel_stat)
          rdata <= {field_60hz, 6'b000000, sync_ok};
        else
          rdata <= in_range ? mem[lin] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/ttx_page_port_chk.sv
module ttx_page_port_chk #(
  parameter int COLS  = 40,
  parameter int ROWS  = 25,
  parameter int DEPTH = 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  addr,
  input logic        wr,
  input logic        rd,
  input logic        field_60hz,
  input logic        sync_ok,
  input logic [7:0]  rdata,
  input logic        busy,
  input logic [87:0] ctrl_o
);
  wire       sel  = ctrl_o[10];
  wire [5:0] col  = ctrl_o[85:80];
  wire       acc  = !busy && addr == 4'd11 && (wr || (rd && !sel));
  int        busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
  end

  AST_REG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr != 4'd11) |=> rdata == 8'h00);  // R1
  AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == DEPTH);  // R3
  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 4'd11 && !busy && sel) |=>
      rdata == {$past(field_60hz), 6'b000000, $past(sync_ok)});  // R6
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && col < 6'(COLS - 1)) |=> col == $past(col) + 6'd1);  // R7
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && col >= 6'(COLS - 1)) |=> col == 6'd0);  // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr == 4'd11 && (rd || wr)) |=> $stable(ctrl_o[87:72]) && $stable(rdata));  // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));  // R9
endmodule

bind ttx_page_port ttx_page_port_chk #(.COLS(COLS), .ROWS(ROWS), .DEPTH(CHAPTERS*ROWS*COLS)) u_chk (.*);

// File: tb/ttx_page_port_tb.sv
`timescale 1ns/1ps
module ttx_page_port_tb;
  localparam int CH = 2, ROWS = 25, COLS = 40, DEPTH = CH * ROWS * COLS;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0, field_60hz = 0, sync_ok = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic busy;
  logic [87:0] ctrl_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ttx_page_port #(.CHAPTERS(CH), .ROWS(ROWS), .COLS(COLS)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic point(input int c, input int r, input int k);
    wreg(4'd8, 8'(c)); wreg(4'd9, 8'(r)); wreg(4'd10, 8'(k));
  endtask

  function automatic logic [7:0] pat(int c, int r, int k);
    return 8'((c * 101 + r * 13 + k * 7 + 5) % 256);
  endfunction

  function automatic logic [7:0] regv(int k);
    return ctrl_o[8*k +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, hold;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 11; k++)
      chk("R2 reset value", regv(k), (k == 5 || k == 6) ? 3 : 0);
    chk("R2 rdata reset", rdata, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R3 fill cycles", n, DEPTH);

    for (int c = 0; c < CH; c++) begin
      point(c, 0, 0);
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < COLS; k++) begin
          rreg(4'd11, v);
          chk("R4 preset byte", v, (c == 0 && r == 0 && k == 7) ? 8'h07 : 8'h20);
        end
      chk("R7 row wrap", regv(9), 0);
      chk("R7 col wrap", regv(10), 0);
    end

    for (int c = 0; c < CH; c++) begin
      point(c, 0, 0);
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < COLS; k++) wreg(4'd11, pat(c, r, k));
      point(c, 0, 0);
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < COLS; k++) begin
          rreg(4'd11, v);
          chk("R5 readback", v, pat(c, r, k));
        end
    end

    point(1, 3, 39);
    wreg(4'd11, 8'h3C);
    chk("R7 col after 39", regv(10), 0);
    chk("R7 row step", regv(9), 4);

    point(8'h08, 23, 0);
    for (int k = 0; k < COLS; k++) wreg(4'd11, 8'(k ^ 8'h5A));
    chk("R7 row after packet", regv(9), 24);
    point(0, 23, 0);
    for (int k = 0; k < COLS; k++) begin
      rreg(4'd11, v);
      chk("R5 packet row", v, k ^ 8'h5A);
    end

    point(0, 2, 9);
    wreg(4'd1, 8'h04);
    field_60hz = 1; sync_ok = 0;
    rreg(4'd11, v); chk("R6 status 60hz", v, 8'h80);
    field_60hz = 0; sync_ok = 1;
    rreg(4'd11, v); chk("R6 status sync", v, 8'h01);
    chk("R6 col unmoved", regv(10), 9);
    wreg(4'd1, 8'h00);
    rreg(4'd11, v); chk("R6 data after status", v, pat(0, 2, 9));

    for (int a = 0; a < 16; a++)
      if (a != 11) begin
        rreg(4'(a), v);
        chk("R1 write-only read", v, 0);
      end
    wreg(4'd3, 8'hA7);
    chk("R1 register stored", regv(3), 8'hA7);

    point(0, 0, 0);
    rreg(4'd11, v);
    hold = rdata;
    repeat (3) @(negedge clk);
    chk("R9 rdata held", rdata, hold);
    wreg(4'd11, 8'h99);
    chk("R9 rdata held over write", rdata, hold);

    point(5, 0, 0);
    wreg(4'd11, 8'h55);
    chk("R10 col advances", regv(10), 1);
    point(5, 0, 0);
    rreg(4'd11, v);
    chk("R10 outside read", v, 0);
    point(0, 22, 24);
    rreg(4'd11, v);
    chk("R10 no alias write", v, pat(0, 22, 24));

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    wreg(4'd10, 8'd5);
    hold = rdata;
    wreg(4'd11, 8'hAA);
    rreg(4'd11, v);
    chk("R8 busy still", busy, 1);
    chk("R8 pointer held", regv(10), 5);
    chk("R8 rdata held", v, hold);
    while (busy) @(negedge clk);
    point(0, 0, 5);
    rreg(4'd11, v);
    chk("R4 preset after refill", v, 8'h20);
    point(0, 0, 7);
    rreg(4'd11, v);
    chk("R4 attribute byte", v, 8'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule